// File: doc/BRIEF.md
# Staggered Module Turn-On Sequencer

This block drives the enable lines of a stack of series-connected power modules. When a start request is accepted, it works out from a voltage setpoint how many fixed step modules are needed. It then switches those modules on one at a time, with a programmable gap between steps, and keeps them on for a programmable working time. After that it switches them off one at a time, in reverse order, using the same gap. A separate trim-module enable sits above the step enables and is raised only while the full set is holding.

All timing is counted in ticks. A tick is produced by dividing the system clock, so the default setting gives 1 µs steps from a 100 MHz clock. In pulse mode the enables follow the ramp directly. In modulation mode every enable is additionally gated by a tick-based square wave with a programmable period and on-time. A fault input removes every enable in the same cycle, whatever the sequence is doing, and returns the sequencer to idle.

Top module: `staggered_ramp_seq`

## Requirements
- R1: While reset is held, and after it is released, all enables are low, `done_o` is low and the sequencer is idle.
- R2: On an accepted start, the step-module count is floor(`setpoint_i` / 810), limited to 83. This count and all other settings are captured at that edge.
- R3: A tick occurs every `TICK_DIV` clocks, with the phase restarted at the accepted start edge. Step module j (bit j of `en_o`, counting from bit 0) turns on at tick (j+1)·g, where g is the gap. Modules turn on one at a time in ascending order, and a gap of 0 counts as 1.
- R4: Once the last module is on, all n modules stay on for w ticks, where a working time of 0 counts as 1. The trim enable, bit 83 of `en_o`, is high only during the ticks n·g to n·g+w−1.
- R5: Modules then turn off in descending order at the same gap. Step module j turns off at tick n·g + w + (n−j)·g.
- R6: `done_o` is high for exactly one clock, at tick 2·n·g + w. A count of 0 goes straight to the hold and gives done at tick w.
- R7: `mode_i` = 0 selects pulse mode, with no gating. `mode_i` = 1 selects modulation mode: with t as the number of ticks since start and P as the period (0 counts as 1), every enable bit is forced low while (t mod P) ≥ `duty_i`.
- R8: While `fault_i` is high, `en_o` is all zero in the same cycle. A fault aborts the sequence to idle without a done pulse, and the enables stay low after the fault clears. A start that arrives together with a fault is ignored.
- R9: A start while a sequence is running is ignored. Changing the inputs after the start has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted when idle and no fault |
| setpoint_i | input | 17 | Voltage setpoint in volts |
| gap_i | input | 20 | Ticks between successive module switch events |
| work_i | input | 24 | Hold time in ticks |
| mode_i | input | 1 | 0 pulse, 1 modulation |
| period_i | input | 20 | Modulation period in ticks |
| duty_i | input | 20 | Modulation on-time in ticks |
| fault_i | input | 1 | Fault, clears all enables at once |
| en_o | output | 84 | Step enables [82:0], trim enable [83] |
| done_o | output | 1 | One-cycle pulse when the off ramp completes |

## Verification
A fault can arrive on the very clock edge at which the sequencer is due to switch the next module on, so a protective clear and a scheduled step contend in the same cycle. The bench raises the fault just before the edge of the second ramp tick. It checks that `en_o` falls to zero combinationally, that the pending step never appears and that no done pulse follows. A start presented together with a fault is judged the same way: the enables must stay low for the whole window in which the first step would otherwise have appeared.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_UP   = 2'd1,
      ST_HOLD = 2'd2,
      ST_DOWN = 2'd3
   } seq_state_e;

   typedef enum logic {
      MODE_PULSE = 1'b0,
      MODE_MOD   = 1'b1
   } seq_mode_e;
endpackage

// File: rtl/seq_tick_gen.sv
`timescale 1ns/1ps
module seq_tick_gen #(
   parameter int DIV = 100
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic restart_i,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_every
         logic unused_in;
         assign unused_in = clk_i ^ rst_i ^ restart_i;
         assign tick_o = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk_i) begin
            if (rst_i || restart_i) cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else cnt_q <= cnt_q + CW'(1);
         end
         assign tick_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/seq_count_calc.sv
`timescale 1ns/1ps
module seq_count_calc #(
   parameter int SET_W   = 17,
   parameter int STEP_V  = 810,
   parameter int STEPS   = 83,
   parameter int CNT_W   = 7
) (
   input  logic [SET_W-1:0] setpoint_i,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [SET_W-1:0] STEP_VW = SET_W'(STEP_V);
   localparam logic [SET_W-1:0] LIMIT   = SET_W'(STEPS);
   logic [SET_W-1:0] quot;
   always_comb begin
      quot = setpoint_i / STEP_VW;
      if (quot > LIMIT) count_o = CNT_W'(STEPS);
      else              count_o = quot[CNT_W-1:0];
   end
endmodule

// File: rtl/seq_mod_gate.sv
`timescale 1ns/1ps
module seq_mod_gate #(
   parameter int MOD_W = 20
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             restart_i,
   input  logic             tick_i,
   input  logic             mod_en_i,
   input  logic [MOD_W-1:0] period_i,
   input  logic [MOD_W-1:0] duty_i,
   output logic             gate_o
);
   logic [MOD_W-1:0] phase_q;
   logic [MOD_W-1:0] per_eff;
   assign per_eff = (period_i == '0) ? MOD_W'(1) : period_i;

   always_ff @(posedge clk_i) begin
      if (rst_i || restart_i) phase_q <= '0;
      else if (tick_i) begin
         if (phase_q >= per_eff - MOD_W'(1)) phase_q <= '0;
         else phase_q <= phase_q + MOD_W'(1);
      end
   end

   assign gate_o = !mod_en_i || (phase_q < duty_i);
endmodule

// File: rtl/staggered_ramp_seq.sv
`timescale 1ns/1ps
module staggered_ramp_seq #(
   parameter int STEPS    = 83,
   parameter int STEP_V   = 810,
   parameter int TICK_DIV = 100,
   parameter int SET_W    = 17,
   parameter int GAP_W    = 20,
   parameter int WORK_W   = 24,
   parameter int MOD_W    = 20,
   localparam int TOT     = STEPS + 1,
   localparam int CNT_W   = $clog2(STEPS + 1)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              start_i,
   input  logic [SET_W-1:0]  setpoint_i,
   input  logic [GAP_W-1:0]  gap_i,
   input  logic [WORK_W-1:0] work_i,
   input  logic              mode_i,
   input  logic [MOD_W-1:0]  period_i,
   input  logic [MOD_W-1:0]  duty_i,
   input  logic              fault_i,
   output logic [TOT-1:0]    en_o,
   output logic              done_o
);
   import seq_pkg::*;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (STEPS < 1) begin : g_bad_steps
         $error("STEPS must be at least 1");
      end
      if (STEP_V < 1) begin : g_bad_stepv
         $error("STEP_V must be at least 1");
      end
   endgenerate

   seq_state_e        state_q;
   logic [STEPS-1:0]  step_q;
   logic [CNT_W-1:0]  idx_q, n_q, n_calc;
   logic [GAP_W-1:0]  gap_q, gap_cnt_q;
   logic [WORK_W-1:0] work_q, work_cnt_q;
   logic              mode_q, done_q;
   logic [MOD_W-1:0]  per_q, duty_q;
   logic              accept, tick, gate;

   assign accept = (state_q == ST_IDLE) && start_i && !fault_i;

   seq_count_calc #(.SET_W(SET_W), .STEP_V(STEP_V), .STEPS(STEPS), .CNT_W(CNT_W))
      u_calc (.setpoint_i(setpoint_i), .count_o(n_calc));

   seq_tick_gen #(.DIV(TICK_DIV))
      u_tick (.clk_i(clk_i), .rst_i(rst_i), .restart_i(accept), .tick_o(tick));

   seq_mod_gate #(.MOD_W(MOD_W))
      u_gate (.clk_i(clk_i), .rst_i(rst_i), .restart_i(accept), .tick_i(tick),
              .mod_en_i(mode_q == MODE_MOD), .period_i(per_q), .duty_i(duty_q),
              .gate_o(gate));

   always_ff @(posedge clk_i) begin
      if (rst_i || fault_i) begin
         state_q    <= ST_IDLE;
         step_q     <= '0;
         idx_q      <= '0;
         gap_cnt_q  <= '0;
         work_cnt_q <= '0;
         done_q     <= 1'b0;
         if (rst_i) begin
            n_q    <= '0;
            gap_q  <= GAP_W'(1);
            work_q <= WORK_W'(1);
            mode_q <= MODE_PULSE;
            per_q  <= MOD_W'(1);
            duty_q <= '0;
         end
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  n_q        <= n_calc;
                  gap_q      <= (gap_i == '0) ? GAP_W'(1) : gap_i;
                  work_q     <= (work_i == '0) ? WORK_W'(1) : work_i;
                  mode_q     <= mode_i;
                  per_q      <= period_i;
                  duty_q     <= duty_i;
                  idx_q      <= '0;
                  gap_cnt_q  <= '0;
                  work_cnt_q <= '0;
                  state_q    <= (n_calc == '0) ? ST_HOLD : ST_UP;
               end
            end
            ST_UP: begin
               if (tick) begin
                  if (gap_cnt_q == gap_q - GAP_W'(1)) begin
                     gap_cnt_q     <= '0;
                     step_q[idx_q] <= 1'b1;
                     idx_q         <= idx_q + CNT_W'(1);
                     if (idx_q + CNT_W'(1) == n_q) begin
                        state_q    <= ST_HOLD;
                        work_cnt_q <= '0;
                     end
                  end else begin
                     gap_cnt_q <= gap_cnt_q + GAP_W'(1);
                  end
               end
            end
            ST_HOLD: begin
               if (tick) begin
                  if (work_cnt_q == work_q - WORK_W'(1)) begin
                     gap_cnt_q <= '0;
                     if (n_q == '0) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        state_q <= ST_DOWN;
                     end
                  end else begin
                     work_cnt_q <= work_cnt_q + WORK_W'(1);
                  end
               end
            end
            ST_DOWN: begin
               if (tick) begin
                  if (gap_cnt_q == gap_q - GAP_W'(1)) begin
                     gap_cnt_q                 <= '0;
                     step_q[idx_q - CNT_W'(1)] <= 1'b0;
                     idx_q                     <= idx_q - CNT_W'(1);
                     if (idx_q == CNT_W'(1)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end
                  end else begin
                     gap_cnt_q <= gap_cnt_q + GAP_W'(1);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   logic [TOT-1:0] en_raw;
   assign en_raw = {(state_q == ST_HOLD), step_q};
   assign en_o   = (fault_i || !gate) ? '0 : en_raw;
   assign done_o = done_q;
endmodule

// File: rtl/seq_ramp_chk.sv
`timescale 1ns/1ps
module seq_ramp_chk #(
   parameter int STEPS = 83
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             fault_i,
   input logic             done_o,
   input logic [STEPS:0]   en_o,
   input logic [STEPS-1:0] step_q
);
   // R8: one cycle after a fault every step enable is low
   a_r8_fault_clear: assert property (@(posedge clk_i) disable iff (rst_i)
      fault_i |=> (en_o[STEPS-1:0] == '0));

   // R3 / R5: at most one step module changes per clock
   a_r3_single_step: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(fault_i) |-> ($countones(step_q ^ $past(step_q)) <= 1));

   // R3 / R5: step set is always a contiguous run from bit 0
   a_r3_thermometer: assert property (@(posedge clk_i) disable iff (rst_i)
      ((step_q & (step_q + STEPS'(1))) == '0));

   // R6: done only once every module is off
   a_r6_done_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> (en_o == '0));
endmodule

bind staggered_ramp_seq seq_ramp_chk #(.STEPS(STEPS)) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .fault_i(fault_i), .done_o(done_o),
   .en_o(en_o), .step_q(step_q));

// File: tb/tb_staggered_ramp_seq.sv
`timescale 1ns/1ps
module tb_staggered_ramp_seq;
   localparam int DIV = 4;
   localparam int TOT = 84;

   typedef struct packed {
      int sp; int gap; int work; int md; int per; int duty;
   } vec_t;

   // R2 R3 R4 R5 R6 R7 vectors
   localparam vec_t VECS [8] = '{
      '{2430,  2, 3,  0, 1, 0},   // n=3 basic pulse, poked with a late start (R9)
      '{3239,  1, 1,  0, 1, 0},   // floor: n=3 (R2)
      '{3240,  0, 2,  0, 1, 0},   // n=4, gap 0 as 1 (R3)
      '{4050,  3, 10, 1, 4, 2},   // modulation 50% (R7)
      '{80000, 1, 2,  0, 1, 0},   // clamp to 83 (R2)
      '{500,   2, 3,  0, 1, 0},   // n=0 (R6)
      '{2430,  1, 8,  1, 3, 5},   // duty >= period, always on (R7)
      '{1620,  2, 4,  1, 5, 0}    // duty 0, always off (R7)
   };

   logic        clk = 0, rst = 1, start = 0, mode = 0, fault = 0;
   logic [16:0] setpoint = '0;
   logic [19:0] gap = '0, period = '0, duty = '0;
   logic [23:0] work = '0;
   logic [TOT-1:0] en;
   logic        done;
   int tests = 0, fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   staggered_ramp_seq #(.TICK_DIV(DIV)) dut (
      .clk_i(clk), .rst_i(rst), .start_i(start), .setpoint_i(setpoint),
      .gap_i(gap), .work_i(work), .mode_i(mode), .period_i(period),
      .duty_i(duty), .fault_i(fault), .en_o(en), .done_o(done));

   function automatic logic [TOT-1:0] expect_en(int n, int g, int w, int md, int p, int d, int t);
      logic [TOT-1:0] v;
      int k;
      bit trim;
      trim = 0;
      if (t < n*g) k = t / g;
      else if (t < n*g + w) begin k = n; trim = 1; end
      else if (t < 2*n*g + w) k = n - (t - n*g - w) / g;
      else k = 0;
      v = (TOT'(1) << k) - TOT'(1);
      v[TOT-1] = trim;
      if (md == 1 && (t % p) >= d) v = '0;
      return v;
   endfunction

   task automatic run_vec(int i, bit poke);
      int n, g, w, p, last, dcount, c;
      bit bad;
      logic [TOT-1:0] exp_v;
      n = VECS[i].sp / 810; if (n > 83) n = 83;
      g = (VECS[i].gap == 0) ? 1 : VECS[i].gap;
      w = (VECS[i].work == 0) ? 1 : VECS[i].work;
      p = (VECS[i].per == 0) ? 1 : VECS[i].per;
      @(negedge clk);
      setpoint = 17'(VECS[i].sp); gap = 20'(VECS[i].gap); work = 24'(VECS[i].work);
      mode = VECS[i].md[0]; period = 20'(VECS[i].per); duty = 20'(VECS[i].duty);
      start = 1;
      last = (2*n*g + w) * DIV;
      bad = 0; dcount = 0;
      for (c = 0; c <= last + 3; c++) begin
         @(negedge clk);
         start = 0;
         if (poke && c == 3) begin
            start = 1; setpoint = 17'd80000; gap = 20'd1; work = 24'd1; mode = 1'b1; // R9
         end
         exp_v = expect_en(n, g, w, VECS[i].md, p, VECS[i].duty, c / DIV);
         if (en !== exp_v && !bad) begin
            bad = 1;
            $display("FAIL R3/R4/R5/R7 vec %0d cycle %0d: en=%h expected %h", i, c, en, exp_v);
         end
         if (done) begin
            dcount++;
            if (c != last && dcount == 1)
               $display("FAIL R6 vec %0d: done at cycle %0d expected %0d", i, c, last);
         end
      end
      tests++; if (bad) fails++;
      tests++;
      if (dcount != 1) begin
         fails++;
         $display("FAIL R6 vec %0d: done pulses=%0d expected 1", i, dcount);
      end
   endtask

   task automatic chk(bit ok, string msg);
      tests++;
      if (!ok) begin fails++; $display("FAIL %s", msg); end
   endtask

   initial begin
      int zero_bad;
      repeat (3) @(negedge clk);
      chk(en == '0 && done == 0, $sformatf("R1 reset: en=%h done=%b expected 0 0", en, done));
      rst = 0;
      @(negedge clk);
      chk(en == '0 && done == 0, $sformatf("R1 after reset: en=%h done=%b expected 0 0", en, done));

      for (int i = 0; i < 8; i++) run_vec(i, i == 0);

      // R8: fault lands on the edge of the second ramp step
      @(negedge clk);
      setpoint = 17'd4050; gap = 20'd1; work = 24'd5; mode = 0; start = 1;
      @(negedge clk); start = 0;                 // c = 0
      repeat (2*DIV - 1) @(negedge clk);         // c = 2*DIV-1, module 0 on
      chk(en[0] == 1'b1, $sformatf("R3 pre-fault: en[0]=%b expected 1", en[0]));
      fault = 1; #1;
      chk(en == '0, $sformatf("R8 same-cycle clear: en=%h expected 0", en));
      @(negedge clk);
      chk(en == '0, $sformatf("R8 step on fault edge: en=%h expected 0", en));
      fault = 0;
      zero_bad = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (en != '0 || done) zero_bad++;
      end
      chk(zero_bad == 0, $sformatf("R8 after fault release: bad cycles=%0d expected 0", zero_bad));

      // R8: start together with fault is ignored
      setpoint = 17'd2430; gap = 20'd1; work = 24'd2; start = 1; fault = 1;
      @(negedge clk); start = 0; fault = 0;
      zero_bad = 0;
      for (int k = 0; k < 8*DIV; k++) begin
         @(negedge clk);
         if (en != '0 || done) zero_bad++;
      end
      chk(zero_bad == 0, $sformatf("R8 start during fault: bad cycles=%0d expected 0", zero_bad));

      // R2: after the fault the block still starts normally
      start = 1;
      @(negedge clk); start = 0;
      repeat (DIV) @(negedge clk);
      chk(en[2:0] == 3'b001, $sformatf("R2 restart: en=%h expected bit0 only", en[2:0]));

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule